// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block expands one scalar-style operation into a run of per-element issues. Each operand (the destination and two sources) carries its own tag that marks it scalar or vector. A scalar operand names the same register on every iteration. A vector operand's register number advances by one per element. A predicate mask picks the active elements. A loop-length input (VL, 0 to 64) bounds the run. A zeroing flag chooses what happens at masked-out elements: they are either left untouched or written with zero.

The handshake is start, busy and done. A start pulse in the idle state captures the whole command. From then on the block issues one element per clock. For each element it presents the element index, the three register numbers, a write enable, a zero-write flag and the write data. The write data comes from a plain adder that stands in for the execution unit. The operand data arrives on two inputs from an external register file.

Because the tags are independent, one loop covers four cases:
- all scalar: behaves as a single plain instruction;
- scalar sources with a vector destination: splat;
- a single-bit mask: insert at one index;
- all vector: ordinary predicated vector operation.

The controller has three states:
- IDLE: waiting for a command. A start moves it to RUN, or to FINISH when VL is zero.
- RUN: issues one element per clock. It moves to FINISH after the last element, or after the first active element when the destination is scalar.
- FINISH: asserts done for one cycle, then returns to IDLE.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset the block is idle. busy, done, issue_valid, wr_en and wr_zero are all 0.
- R2: A start in the idle state with VL>0 makes busy and issue_valid 1 from the next cycle. The issues come one per clock, with issue_idx counting 0, 1, 2 and so on without gaps.
- R3: At element index e, a vector-tagged operand's register number is its base plus e, modulo 2^REG_W. A scalar-tagged operand's register number equals its base.
- R4: When all three operands are vector and mask bit e is 1, element e has wr_en=1, wr_zero=0 and wr_data = op1_data + op2_data (modulo 2^DATA_W).
- R5: With zeroing=0, an element whose mask bit is 0 has wr_en=0.
- R6: With zeroing=1 and a vector destination, an element whose mask bit is 0 has wr_en=1, wr_zero=1 and wr_data=0.
- R7: With a scalar destination, the run ends after the first element whose mask bit is 1. Earlier masked elements have wr_en=0 even when zeroing=1. If no bit in the range is set, the run covers all VL elements.
- R8: With all operands scalar, VL=1 and mask bit 0 set, exactly one element is issued. It writes the base destination register using the base source registers.
- R9: With scalar sources and a vector destination, every active element reads the two base source registers and writes destination base plus e (splat).
- R10: A mask with only bit k set and zeroing=0 gives exactly one write, at element k (insert).
- R11: A start with VL=0 issues no element. done is 1 in the next cycle.
- R12: done is a one-cycle pulse in the cycle after the last issued element. busy is 0 while done is 1, and the block is idle afterwards.
- R13: start is ignored while the block is busy. The running loop's count and registers are unchanged.
- R14: VL=64 issues all 64 elements, indices 0 to 63. Vector register numbers wrap modulo 2^REG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, accepted only when idle |
| vl | input | 7 | Loop length, 0 to 64 |
| mask | input | 64 | Predicate, bit e enables element e |
| zeroing | input | 1 | 1 = masked-out vector destination elements are written with zero |
| rd_vec | input | 1 | Destination tag, 1 = vector |
| rs1_vec | input | 1 | Source 1 tag, 1 = vector |
| rs2_vec | input | 1 | Source 2 tag, 1 = vector |
| rd_base | input | 7 | Destination base register |
| rs1_base | input | 7 | Source 1 base register |
| rs2_base | input | 7 | Source 2 base register |
| op1_data | input | 16 | Source 1 data for the current element |
| op2_data | input | 16 | Source 2 data for the current element |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| issue_valid | output | 1 | An element is presented this cycle |
| issue_idx | output | 6 | Element index |
| rd_num | output | 7 | Destination register number |
| rs1_num | output | 7 | Source 1 register number |
| rs2_num | output | 7 | Source 2 register number |
| wr_en | output | 1 | Write the destination this cycle |
| wr_zero | output | 1 | The write carries zero because the element is masked |
| wr_data | output | 16 | Write data |

## Verification
The bench checks the corner cases below.

- **Zeroing with a scalar destination.** A design that zeroed masked elements regardless of the destination tag would clobber the scalar register before the real result arrived.
- **Early exit with a scalar destination.** A design that missed this stop would keep issuing to the same register.
- **VL of zero.** A design that did not special-case it would issue element 0, or wrap its counter and run 64 times.
- **Full length of 64 with wrapping register numbers.** This exposes an off-by-one end test or a counter too narrow for the last index.
- **A second start during a run.** A design that reloaded its command would restart the index or change registers mid-loop.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;

    localparam int N_OPND = 3;
    localparam int OPND_RD  = 0;
    localparam int OPND_RS1 = 1;
    localparam int OPND_RS2 = 2;

endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int MAX_VL = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(MAX_VL):0]      vl,
    input  logic [MAX_VL-1:0]            mask,
    input  logic                         zeroing,
    input  logic                         rd_vec,
    output logic                         accept,
    output logic                         busy,
    output logic                         done,
    output logic                         issue_valid,
    output logic [$clog2(MAX_VL)-1:0]    issue_idx,
    output logic                         wr_en,
    output logic                         wr_zero
);
    localparam int IDXW = $clog2(MAX_VL);
    localparam int VLW  = IDXW + 1;

    seq_state_e           state_q, state_d;
    logic [IDXW-1:0]      cnt_q;
    logic [VLW-1:0]       cfg_vl_q;
    logic [MAX_VL-1:0]    cfg_mask_q;
    logic                 cfg_zero_q;
    logic                 cfg_rdv_q;
    logic                 active;
    logic                 last_elem;

    assign accept    = (state_q == ST_IDLE) && start;
    assign active    = cfg_mask_q[cnt_q];
    assign last_elem = ({1'b0, cnt_q} == (cfg_vl_q - VLW'(1))) ||
                       (!cfg_rdv_q && active);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (vl == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (last_elem) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register, element counter and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            cfg_vl_q   <= '0;
            cfg_mask_q <= '0;
            cfg_zero_q <= 1'b0;
            cfg_rdv_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q      <= '0;
                cfg_vl_q   <= vl;
                cfg_mask_q <= mask;
                cfg_zero_q <= zeroing;
                cfg_rdv_q  <= rd_vec;
            end else if (state_q == ST_RUN && !last_elem) begin
                cnt_q <= cnt_q + IDXW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        issue_valid = 1'b0;
        wr_en       = 1'b0;
        wr_zero     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy        = 1'b1;
                issue_valid = 1'b1;
                wr_en       = active || (cfg_zero_q && cfg_rdv_q);
                wr_zero     = !active && cfg_zero_q && cfg_rdv_q;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign issue_idx = cnt_q;

endmodule

// File: rtl/vseq_regsel.sv
module vseq_regsel
    import vseq_pkg::*;
#(
    parameter int REG_W = 7,
    parameter int IDXW  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic [N_OPND-1:0]             vec_tag,
    input  logic [N_OPND-1:0][REG_W-1:0]  base,
    input  logic [IDXW-1:0]               idx,
    output logic [N_OPND-1:0][REG_W-1:0]  num
);
    logic [N_OPND-1:0]            tag_q;
    logic [N_OPND-1:0][REG_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            tag_q  <= vec_tag;
            base_q <= base;
        end
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        assign num[g] = base_q[g] + (tag_q[g] ? REG_W'(idx) : REG_W'(0));
    end

endmodule

// File: rtl/vseq_alu.sv
module vseq_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              force_zero,
    output logic [DATA_W-1:0] y
);
    assign y = force_zero ? '0 : (a + b);
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int REG_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [$clog2(MAX_VL):0]     vl,
    input  logic [MAX_VL-1:0]           mask,
    input  logic                        zeroing,
    input  logic                        rd_vec,
    input  logic                        rs1_vec,
    input  logic                        rs2_vec,
    input  logic [REG_W-1:0]            rd_base,
    input  logic [REG_W-1:0]            rs1_base,
    input  logic [REG_W-1:0]            rs2_base,
    input  logic [DATA_W-1:0]           op1_data,
    input  logic [DATA_W-1:0]           op2_data,
    output logic                        busy,
    output logic                        done,
    output logic                        issue_valid,
    output logic [$clog2(MAX_VL)-1:0]   issue_idx,
    output logic [REG_W-1:0]            rd_num,
    output logic [REG_W-1:0]            rs1_num,
    output logic [REG_W-1:0]            rs2_num,
    output logic                        wr_en,
    output logic                        wr_zero,
    output logic [DATA_W-1:0]           wr_data
);
    localparam int IDXW = $clog2(MAX_VL);

    logic                          accept;
    logic [N_OPND-1:0]             tags;
    logic [N_OPND-1:0][REG_W-1:0]  bases;
    logic [N_OPND-1:0][REG_W-1:0]  nums;

    assign tags[OPND_RD]   = rd_vec;
    assign tags[OPND_RS1]  = rs1_vec;
    assign tags[OPND_RS2]  = rs2_vec;
    assign bases[OPND_RD]  = rd_base;
    assign bases[OPND_RS1] = rs1_base;
    assign bases[OPND_RS2] = rs2_base;

    vseq_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .mask(mask),
        .zeroing(zeroing), .rd_vec(rd_vec), .accept(accept), .busy(busy),
        .done(done), .issue_valid(issue_valid), .issue_idx(issue_idx),
        .wr_en(wr_en), .wr_zero(wr_zero)
    );

    vseq_regsel #(.REG_W(REG_W), .IDXW(IDXW)) u_regsel (
        .clk(clk), .rst_n(rst_n), .accept(accept), .vec_tag(tags),
        .base(bases), .idx(issue_idx), .num(nums)
    );

    vseq_alu #(.DATA_W(DATA_W)) u_alu (
        .a(op1_data), .b(op2_data), .force_zero(wr_zero), .y(wr_data)
    );

    assign rd_num  = nums[OPND_RD];
    assign rs1_num = nums[OPND_RS1];
    assign rs2_num = nums[OPND_RS2];

endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
    parameter int MAX_VL = 64,
    parameter int DATA_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic [$clog2(MAX_VL):0]    vl,
    input logic                       busy,
    input logic                       done,
    input logic                       issue_valid,
    input logic [$clog2(MAX_VL)-1:0]  issue_idx,
    input logic                       wr_en,
    input logic                       wr_zero,
    input logic [DATA_W-1:0]          wr_data
);
    p_issue_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> busy);

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && $past(issue_valid)) |-> issue_idx == $past(issue_idx) + 1'b1);

    p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (!wr_en && !wr_zero));

    p_zero_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_zero |-> (wr_en && wr_data == '0));

    p_empty_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && vl == '0) |=> (done && !issue_valid));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && vl != '0) |=> (busy && issue_valid && issue_idx == '0));
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .busy(busy), .done(done),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .wr_en(wr_en),
    .wr_zero(wr_zero), .wr_data(wr_data)
);

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb;
    localparam int MAX_VL = 64;
    localparam int REG_W  = 7;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [6:0]  vl;
        logic [63:0] msk;
        logic        z;
        logic        rdv;
        logic        s1v;
        logic        s2v;
        logic [6:0]  rdb;
        logic [6:0]  s1b;
        logic [6:0]  s2b;
    } row_t;

    localparam int NROW = 8;
    localparam row_t TBL [NROW] = '{
        '{7'd5,  64'h1F,                 1'b0, 1'b1, 1'b1, 1'b1, 7'd10,  7'd20, 7'd30},
        '{7'd6,  64'h2D,                 1'b0, 1'b1, 1'b1, 1'b1, 7'd40,  7'd50, 7'd60},
        '{7'd6,  64'h2D,                 1'b1, 1'b1, 1'b1, 1'b1, 7'd40,  7'd50, 7'd60},
        '{7'd1,  64'h1,                  1'b0, 1'b0, 1'b0, 1'b0, 7'd3,   7'd4,  7'd5},
        '{7'd4,  64'hF,                  1'b0, 1'b1, 1'b0, 1'b0, 7'd8,   7'd1,  7'd2},
        '{7'd8,  64'h20,                 1'b0, 1'b1, 1'b1, 1'b1, 7'd16,  7'd32, 7'd48},
        '{7'd6,  64'h0C,                 1'b1, 1'b0, 1'b1, 1'b1, 7'd9,   7'd11, 7'd70},
        '{7'd64, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 1'b1, 1'b1, 1'b0, 7'd100, 7'd90, 7'd7}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [6:0]        vl = '0;
    logic [63:0]       mask = '0;
    logic              zeroing = 1'b0;
    logic              rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
    logic [REG_W-1:0]  rd_base = '0, rs1_base = '0, rs2_base = '0;
    logic [DATA_W-1:0] op1_data = '0, op2_data = '0;
    logic              busy, done, issue_valid, wr_en, wr_zero;
    logic [5:0]        issue_idx;
    logic [REG_W-1:0]  rd_num, rs1_num, rs2_num;
    logic [DATA_W-1:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vec_elem_seq #(.MAX_VL(MAX_VL), .REG_W(REG_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .mask(mask),
        .zeroing(zeroing), .rd_vec(rd_vec), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec),
        .rd_base(rd_base), .rs1_base(rs1_base), .rs2_base(rs2_base),
        .op1_data(op1_data), .op2_data(op2_data), .busy(busy), .done(done),
        .issue_valid(issue_valid), .issue_idx(issue_idx), .rd_num(rd_num),
        .rs1_num(rs1_num), .rs2_num(rs2_num), .wr_en(wr_en), .wr_zero(wr_zero),
        .wr_data(wr_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic launch(input row_t r);
        @(negedge clk);
        vl = r.vl; mask = r.msk; zeroing = r.z;
        rd_vec = r.rdv; rs1_vec = r.s1v; rs2_vec = r.s2v;
        rd_base = r.rdb; rs1_base = r.s1b; rs2_base = r.s2b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // walk one command and compare every issued element against the rules
    task automatic run_row(input row_t r, input string lbl);
        int n;
        int first;
        n = r.vl;
        if (!r.rdv) begin
            first = -1;
            for (int k = 0; k < r.vl; k++)
                if (first < 0 && r.msk[k]) first = k;
            if (first >= 0) n = first + 1;
        end
        launch(r);
        for (int e = 0; e < n; e++) begin
            logic act_bit, ew, ez;
            act_bit = r.msk[e];
            ew = act_bit || (r.z && r.rdv);
            ez = !act_bit && r.z && r.rdv;
            chk("R2", "issue_valid", issue_valid, 1);
            chk("R2", "issue_idx", issue_idx, e);
            chk("R3", "rd_num",  rd_num,  7'(r.rdb + (r.rdv ? e : 0)));
            chk("R3", "rs1_num", rs1_num, 7'(r.s1b + (r.s1v ? e : 0)));
            chk("R3", "rs2_num", rs2_num, 7'(r.s2b + (r.s2v ? e : 0)));
            chk(lbl, "wr_en", wr_en, ew);
            chk(lbl, "wr_zero", wr_zero, ez);
            if (ew)
                chk(lbl, "wr_data", wr_data, ez ? 16'h0 : 16'(op1_data + op2_data));
            @(negedge clk);
        end
        chk("R12", "done after last", done, 1);
        chk("R12", "busy with done", busy, 0);
        @(negedge clk);
        chk("R12", "done pulse width", done, 0);
        chk("R12", "idle after done", issue_valid, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        string lbl;
        row_t r;
        int cnt;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "issue_valid", issue_valid, 0);
        chk("R1", "wr_en", wr_en, 0);
        chk("R1", "wr_zero", wr_zero, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset release", busy, 0);

        for (int i = 0; i < NROW; i++) begin
            case (i)
                0: lbl = "R4";
                1: lbl = "R5";
                2: lbl = "R6";
                3: lbl = "R8";
                4: lbl = "R9";
                5: lbl = "R10";
                6: lbl = "R7";
                default: lbl = "R14";
            endcase
            op1_data = 16'h0100 + 16'(i * 16'h111);
            op2_data = 16'hFF00 + 16'(i);
            run_row(TBL[i], lbl);
        end

        // R10 insert: count writes on a single-bit mask
        r = TBL[5];
        launch(r);
        cnt = 0;
        for (int e = 0; e < 8; e++) begin
            if (wr_en) begin
                cnt++;
                chk("R10", "insert index", issue_idx, 5);
            end
            @(negedge clk);
        end
        chk("R10", "insert write count", cnt, 1);
        @(negedge clk);

        // R7 scalar destination with no active bit runs full length
        r = '{7'd3, 64'h0, 1'b1, 1'b0, 1'b1, 1'b1, 7'd1, 7'd2, 7'd3};
        run_row(r, "R7");

        // R11 empty loop
        r = '{7'd0, 64'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 7'd1, 7'd2, 7'd3};
        launch(r);
        chk("R11", "done on VL=0", done, 1);
        chk("R11", "no issue on VL=0", issue_valid, 0);
        @(negedge clk);
        chk("R11", "done pulse VL=0", done, 0);

        // R13 start while running is ignored
        r = '{7'd4, 64'hF, 1'b0, 1'b1, 1'b1, 1'b1, 7'd20, 7'd30, 7'd40};
        launch(r);
        cnt = 0;
        for (int e = 0; e < 4; e++) begin
            chk("R13", "issue_idx", issue_idx, e);
            chk("R13", "rd_num", rd_num, 7'(20 + e));
            if (issue_valid) cnt++;
            if (e == 1) begin
                start = 1'b1; vl = 7'd9; rd_base = 7'd0; mask = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R13", "issue count", cnt, 4);
        chk("R13", "done after original length", done, 1);
        @(negedge clk);
        chk("R13", "no restart", issue_valid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule